// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block decides whether a small 8-bit microcontroller core is running, idling or powered down. Software raises an idle request or a power-down request; the controller then closes the CPU clock gate, the peripheral clock gate and the oscillator enable as the chosen mode demands. While either low-power mode is active it takes over the external address-latch strobe, the program-store strobe and the low address/data port. The levels it drives depend on the mode and on the program-memory strap.

The reset pin is sampled on every clock. A reset is accepted only after the pin has stayed high for two machine cycles without a break. The qualified reset returns the core to run from any mode, and it is driven out so that the register file can be reinitialised while RAM is left alone. Idle also ends when an enabled interrupt is pending. In that case a one-cycle pulse clears the software idle bit in the same cycle that the CPU clock gate opens again. Power-down is left only through the qualified reset. A high reset pin restarts the oscillator at once, so the qualifier can count.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: `sysReset` goes high at the sample after the 24th consecutive clock edge with `rstPin` high. With the defaults this is 12 clocks per machine cycle times 2 machine cycles. It stays high while the pin stays high. Any low sample restarts the count, so a high run of 23 or fewer edges never asserts it.
- R2: In run, an `idleReq` sampled high enters idle at the next edge. Idle means `cpuClkEn`=0, `periphClkEn`=1 and `oscEn`=1.
- R3: In idle, an `intPend` sampled high with no qualified reset returns to run at that edge. In the cycle that follows, `cpuClkEn`=1 and `idleClr`=1, for exactly one cycle. `idleReq` is ignored during that cycle. If the qualified reset is active in the same cycle, the block returns to run with no `idleClr` pulse.
- R4: In run, a `pdReq` sampled high enters power-down at the next edge, even when `idleReq` is high too. Power-down means `cpuClkEn`=0 and `periphClkEn`=0, with `oscEn`=0 while `rstPin` is low.
- R5: In power-down, `intPend` has no effect and the mode stays power-down.
- R6: A qualified reset sampled at an edge puts the block in run from any mode. In power-down, `oscEn` follows `rstPin` high in the same cycle.
- R7: In idle, `pinOvr`=1, `aleLevel`=1 and `psenLevel`=1.
- R8: In power-down, `pinOvr`=1, `aleLevel`=0 and `psenLevel`=0.
- R9: `port0Float` is 1 exactly when the mode is idle or power-down and `extProg`=1 (external program memory). In run, `pinOvr`=0 and `port0Float`=0.
- R10: `pwrMode` encodes run as 2'b00, idle as 2'b01 and power-down as 2'b10. After power-on reset it reads run, with all clock gates and the oscillator enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| rstPin | input | 1 | Reset pin, sampled every clock |
| idleReq | input | 1 | Software idle request bit |
| pdReq | input | 1 | Software power-down request bit |
| intPend | input | 1 | Any enabled interrupt pending |
| extProg | input | 1 | 1 = code runs from external program memory |
| pwrMode | output | 2 | Current mode code |
| cpuClkEn | output | 1 | CPU clock gate enable |
| periphClkEn | output | 1 | Peripheral clock gate enable |
| oscEn | output | 1 | Oscillator enable |
| pinOvr | output | 1 | Strobe and port override active |
| aleLevel | output | 1 | Forced address-latch strobe level |
| psenLevel | output | 1 | Forced program-store strobe level |
| port0Float | output | 1 | Low address/data port released to high impedance |
| idleClr | output | 1 | One-cycle pulse clearing the idle request bit |
| sysReset | output | 1 | Qualified reset to the rest of the core |

## Verification
An interrupt-driven idle exit and a qualified reset can arrive in the same cycle. The bench parks the core in idle, holds the reset pin for the full qualifying window, and raises `intPend` in the cycle where `sysReset` has just gone high. It then expects run with no `idleClr` pulse. A second collision raises both software requests at once, and power-down must win.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_IDLE  = 2'b01,
    MODE_PDOWN = 2'b10
  } pwrMode_e;

  // strobes from the mode control to the pin/reset datapath
  typedef struct packed {
    logic cpuGateOpen;
    logic perGateOpen;
    logic oscHalt;
    logic pinOverride;
    logic strobeLow;
  } modeStrobes_t;

endpackage

// File: rtl/pmc_mode_ctrl.sv
module pmc_mode_ctrl
  import pmc_pkg::*;
(
  input  logic         clk,
  input  logic         porN,
  input  logic         idleReq,
  input  logic         pdReq,
  input  logic         intPend,
  input  logic         sysReset,
  output pwrMode_e     modeQ,
  output modeStrobes_t strobes,
  output logic         idleClr
);

  pwrMode_e modeNext;
  logic     idleClrQ;
  logic     wakeByInt;

  // interrupt wake only counts when no qualified reset competes
  assign wakeByInt = (modeQ == MODE_IDLE) && intPend && !sysReset;

  always_comb begin
    modeNext = modeQ;
    unique case (modeQ)
      MODE_RUN: begin
        if (pdReq)
          modeNext = MODE_PDOWN;
        else if (idleReq && !idleClrQ)
          modeNext = MODE_IDLE;
      end
      MODE_IDLE: begin
        if (intPend)
          modeNext = MODE_RUN;
      end
      MODE_PDOWN: begin
        modeNext = MODE_PDOWN;
      end
      default: modeNext = MODE_RUN;
    endcase
    if (sysReset)
      modeNext = MODE_RUN;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      modeQ    <= MODE_RUN;
      idleClrQ <= 1'b0;
    end else begin
      modeQ    <= modeNext;
      idleClrQ <= wakeByInt;
    end
  end

  always_comb begin
    strobes.cpuGateOpen = (modeQ == MODE_RUN);
    strobes.perGateOpen = (modeQ != MODE_PDOWN);
    strobes.oscHalt     = (modeQ == MODE_PDOWN);
    strobes.pinOverride = (modeQ != MODE_RUN);
    strobes.strobeLow   = (modeQ == MODE_PDOWN);
  end

  assign idleClr = idleClrQ;

endmodule

// File: rtl/pmc_pin_path.sv
module pmc_pin_path
  import pmc_pkg::*;
#(
  parameter int CLKS_PER_MC = 12,
  parameter int RST_MCS     = 2
) (
  input  logic         clk,
  input  logic         porN,
  input  logic         rstPin,
  input  logic         extProg,
  input  modeStrobes_t strobes,
  output logic         sysReset,
  output logic         cpuClkEn,
  output logic         periphClkEn,
  output logic         oscEn,
  output logic         pinOvr,
  output logic         aleLevel,
  output logic         psenLevel,
  output logic         port0Float
);

  localparam int RST_LEN = CLKS_PER_MC * RST_MCS;
  localparam int CNT_W   = $clog2(RST_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(RST_LEN);

  logic [CNT_W-1:0] highRun;

  // consecutive-high counter, saturating at the qualifying length
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)
      highRun <= '0;
    else if (!rstPin)
      highRun <= '0;
    else if (highRun != CNT_TOP)
      highRun <= highRun + 1'b1;
  end

  assign sysReset = (highRun == CNT_TOP);

  // a high reset pin restarts a halted oscillator so the count can proceed
  assign oscEn       = !strobes.oscHalt || rstPin;
  assign cpuClkEn    = strobes.cpuGateOpen;
  assign periphClkEn = strobes.perGateOpen;
  assign pinOvr      = strobes.pinOverride;
  assign aleLevel    = !strobes.strobeLow;
  assign psenLevel   = !strobes.strobeLow;
  assign port0Float  = strobes.pinOverride && extProg;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int CLKS_PER_MC = 12,
  parameter int RST_MCS     = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       rstPin,
  input  logic       idleReq,
  input  logic       pdReq,
  input  logic       intPend,
  input  logic       extProg,
  output logic [1:0] pwrMode,
  output logic       cpuClkEn,
  output logic       periphClkEn,
  output logic       oscEn,
  output logic       pinOvr,
  output logic       aleLevel,
  output logic       psenLevel,
  output logic       port0Float,
  output logic       idleClr,
  output logic       sysReset
);

  localparam int RST_LEN = CLKS_PER_MC * RST_MCS;

  pwrMode_e     modeQ;
  modeStrobes_t strobes;

  pmc_mode_ctrl u_ctrl (
    .clk      (clk),
    .porN     (porN),
    .idleReq  (idleReq),
    .pdReq    (pdReq),
    .intPend  (intPend),
    .sysReset (sysReset),
    .modeQ    (modeQ),
    .strobes  (strobes),
    .idleClr  (idleClr)
  );

  pmc_pin_path #(
    .CLKS_PER_MC (CLKS_PER_MC),
    .RST_MCS     (RST_MCS)
  ) u_path (
    .clk         (clk),
    .porN        (porN),
    .rstPin      (rstPin),
    .extProg     (extProg),
    .strobes     (strobes),
    .sysReset    (sysReset),
    .cpuClkEn    (cpuClkEn),
    .periphClkEn (periphClkEn),
    .oscEn       (oscEn),
    .pinOvr      (pinOvr),
    .aleLevel    (aleLevel),
    .psenLevel   (psenLevel),
    .port0Float  (port0Float)
  );

  assign pwrMode = modeQ;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int RST_LEN = 24
) (
  input logic       clk,
  input logic       porN,
  input logic       rstPin,
  input logic       intPend,
  input logic       extProg,
  input logic [1:0] pwrMode,
  input logic       cpuClkEn,
  input logic       periphClkEn,
  input logic       oscEn,
  input logic       pinOvr,
  input logic       aleLevel,
  input logic       psenLevel,
  input logic       port0Float,
  input logic       idleClr,
  input logic       sysReset
);

  localparam int W = $clog2(RST_LEN + 1);
  logic [W-1:0] seenHigh;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)
      seenHigh <= '0;
    else if (!rstPin)
      seenHigh <= '0;
    else if (seenHigh != W'(RST_LEN))
      seenHigh <= seenHigh + 1'b1;
  end

  AST_RESET_QUALIFIED: assert property (@(posedge clk) disable iff (!porN)
    sysReset |-> (seenHigh == W'(RST_LEN))); // R1

  AST_IDLE_WAKE_CLEAR: assert property (@(posedge clk) disable iff (!porN)
    (pwrMode == 2'b01 && intPend && !sysReset) |=> (cpuClkEn && idleClr)); // R3

  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!porN)
    idleClr |=> !idleClr); // R3

  AST_PDOWN_GATES: assert property (@(posedge clk) disable iff (!porN)
    (pwrMode == 2'b10 && !rstPin) |-> (!cpuClkEn && !periphClkEn && !oscEn)); // R4

  AST_PDOWN_HOLD: assert property (@(posedge clk) disable iff (!porN)
    (pwrMode == 2'b10 && !sysReset) |=> (pwrMode == 2'b10)); // R5

  AST_RESET_TO_RUN: assert property (@(posedge clk) disable iff (!porN)
    sysReset |=> (pwrMode == 2'b00)); // R6

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!porN)
    (pwrMode == 2'b01) |-> (pinOvr && aleLevel && psenLevel)); // R7

  AST_PDOWN_PINS: assert property (@(posedge clk) disable iff (!porN)
    (pwrMode == 2'b10) |-> (pinOvr && !aleLevel && !psenLevel)); // R8

  AST_PORT_FLOAT: assert property (@(posedge clk) disable iff (!porN)
    port0Float |-> (extProg && pinOvr && pwrMode != 2'b00)); // R9

endmodule

bind pwr_mode_ctrl pmc_checker #(.RST_LEN(RST_LEN)) u_pmcChk (
  .clk         (clk),
  .porN        (porN),
  .rstPin      (rstPin),
  .intPend     (intPend),
  .extProg     (extProg),
  .pwrMode     (pwrMode),
  .cpuClkEn    (cpuClkEn),
  .periphClkEn (periphClkEn),
  .oscEn       (oscEn),
  .pinOvr      (pinOvr),
  .aleLevel    (aleLevel),
  .psenLevel   (psenLevel),
  .port0Float  (port0Float),
  .idleClr     (idleClr),
  .sysReset    (sysReset)
);

// File: tb/pwr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_bench;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic rstPin = 1'b0, idleReq = 1'b0, pdReq = 1'b0, intPend = 1'b0, extProg = 1'b0;
  logic [1:0] pwrMode;
  logic cpuClkEn, periphClkEn, oscEn, pinOvr, aleLevel, psenLevel, port0Float, idleClr, sysReset;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk(clk), .porN(porN), .rstPin(rstPin), .idleReq(idleReq), .pdReq(pdReq),
    .intPend(intPend), .extProg(extProg), .pwrMode(pwrMode), .cpuClkEn(cpuClkEn),
    .periphClkEn(periphClkEn), .oscEn(oscEn), .pinOvr(pinOvr), .aleLevel(aleLevel),
    .psenLevel(psenLevel), .port0Float(port0Float), .idleClr(idleClr), .sysReset(sysReset)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // advance n rising edges, return at the following falling edge
  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R10", "mode after por", pwrMode, 0);
    chk("R10", "cpuClkEn", cpuClkEn, 1);
    chk("R10", "periphClkEn", periphClkEn, 1);
    chk("R10", "oscEn", oscEn, 1);
    chk("R9", "pinOvr in run", pinOvr, 0);
    chk("R9", "port0Float in run", port0Float, 0);
    chk("R1", "sysReset idle", sysReset, 0);
  endtask

  task automatic t_idle_interrupt();
    extProg = 1'b0; idleReq = 1'b1;
    cyc(1);
    chk("R2", "mode idle", pwrMode, 1);
    chk("R2", "cpu gate closed", cpuClkEn, 0);
    chk("R2", "periph runs", periphClkEn, 1);
    chk("R2", "osc runs", oscEn, 1);
    chk("R7", "override", pinOvr, 1);
    chk("R7", "ale high", aleLevel, 1);
    chk("R7", "psen high", psenLevel, 1);
    chk("R9", "port kept internal", port0Float, 0);
    intPend = 1'b1;
    cyc(1);
    chk("R3", "mode run", pwrMode, 0);
    chk("R3", "cpu reopened", cpuClkEn, 1);
    chk("R3", "idleClr pulse", idleClr, 1);
    intPend = 1'b0;  // idleReq still high during the clear cycle
    cyc(1);
    chk("R3", "idleReq ignored while clearing", pwrMode, 0);
    chk("R3", "idleClr single", idleClr, 0);
    idleReq = 1'b0;
    cyc(1);
  endtask

  task automatic t_idle_reset_ext();
    extProg = 1'b1; idleReq = 1'b1;
    cyc(1);
    idleReq = 1'b0;
    chk("R9", "port floats ext idle", port0Float, 1);
    // broken high run: 20 high, 1 low, 23 high
    rstPin = 1'b1; cyc(20);
    rstPin = 1'b0; cyc(1);
    rstPin = 1'b1; cyc(23);
    chk("R1", "23 highs not enough", sysReset, 0);
    chk("R1", "still idle", pwrMode, 1);
    cyc(1);
    chk("R1", "24th high qualifies", sysReset, 1);
    chk("R6", "mode before reset acts", pwrMode, 1);
    cyc(1);
    chk("R6", "idle left by reset", pwrMode, 0);
    rstPin = 1'b0;
    cyc(1);
    chk("R1", "reset drops", sysReset, 0);
  endtask

  task automatic t_pdown();
    extProg = 1'b0; pdReq = 1'b1; idleReq = 1'b1;
    cyc(1);
    pdReq = 1'b0; idleReq = 1'b0;
    chk("R4", "pd wins over idle", pwrMode, 2);
    chk("R4", "cpu off", cpuClkEn, 0);
    chk("R4", "periph off", periphClkEn, 0);
    chk("R4", "osc off", oscEn, 0);
    chk("R8", "override", pinOvr, 1);
    chk("R8", "ale low", aleLevel, 0);
    chk("R8", "psen low", psenLevel, 0);
    chk("R9", "port kept internal pd", port0Float, 0);
    intPend = 1'b1;
    cyc(3);
    chk("R5", "interrupt ignored", pwrMode, 2);
    chk("R5", "cpu stays off", cpuClkEn, 0);
    intPend = 1'b0; extProg = 1'b1;
    cyc(1);
    chk("R9", "port floats ext pd", port0Float, 1);
    rstPin = 1'b1;
    #1;
    chk("R6", "osc restarts on pin", oscEn, 1);
    cyc(24);
    chk("R6", "pd until reset acts", pwrMode, 2);
    cyc(1);
    chk("R6", "pd left by reset", pwrMode, 0);
    chk("R6", "cpu on", cpuClkEn, 1);
    rstPin = 1'b0; extProg = 1'b0;
    cyc(1);
  endtask

  task automatic t_collision();
    idleReq = 1'b1;
    cyc(1);
    idleReq = 1'b0;
    rstPin = 1'b1;
    cyc(24);
    chk("R1", "qualified", sysReset, 1);
    intPend = 1'b1;
    cyc(1);
    chk("R6", "run after tie", pwrMode, 0);
    chk("R3", "no clear on reset wake", idleClr, 0);
    intPend = 1'b0; rstPin = 1'b0;
    cyc(2);
  endtask

  initial begin
    #200_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    porN = 1'b1;
    cyc(1);
    t_reset_state();
    t_idle_interrupt();
    t_idle_reset_ext();
    t_pdown();
    t_collision();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule